// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle control that moves a processor into an interrupt handler and back out. It owns a single word-wide memory port with a request/ready handshake. It takes the current stack pointer, flag word and instruction pointer from the core. When a sequence ends, it hands back the updated values for one cycle so that the core can write them into its register file.

Entry is triggered by a trap (a software interrupt or an exception raised by the core), by a non-maskable hardware error request, or by a maskable platform request. Entry pushes four words onto an upward-growing stack: the old stack pointer, the flag word, the instruction pointer and an error code. It then reads the handler address from a vector table at a fixed base and clears the interrupt-enable bit (bit 4 of the flag word). A return request undoes this. It steps over the error code, then pops the instruction pointer, the flag word and the stack pointer. Two single-cycle requests set and clear the interrupt-enable bit.

Vector numbers 0 to 5 are the core exceptions, and vector 1 is the non-maskable hardware error. Vectors 6 to 15 are reserved, and 16 to 255 belong to platform devices.

Top module: `trap_seq`

## Requirements
- R1: After reset, `busy`, `memReq` and `updValid` are 0.
- R2: A request is taken only while the sequencer is idle and `bndry` is 1. Requests at any other time are ignored. When several requests arrive together, the order of precedence is: trap, then accepted platform request, then return, then set-enable, then clear-enable.
- R3: Entry makes four writes (`memWe`=1) in this order, where S is `curSp` at acceptance. The address S+4 receives S, S+8 receives `curFlg`, S+12 receives `curIp`, and S+16 receives the error code. The error code is `trapCode` for a trap and the zero-extended `irqVec` for a platform request.
- R4: After the four writes, entry reads (`memWe`=0) the word at `VEC_BASE + 4*vector`. This covers every vector from 0 to 255.
- R5: One cycle after the vector read completes, `updValid` is 1. At that point `spOut` is S+16, `ipOut` is the word read from the table, and `flgOut` is the saved flag word with bit 4 cleared.
- R6: A platform request with a vector other than 1 is taken only when `curFlg` bit 4 is 1. A platform request with vector 1 is taken whatever bit 4 holds.
- R7: A return with `curSp` = S performs three reads and no other memory cycle. It reads `ipOut` from S-4, `flgOut` from S-8 and `spOut` from S-12, and `updValid` follows one cycle after the last read.
- R8: An access holds `memReq`, `memAddr`, `memWe` and `memWdata` unchanged until a cycle with `memRdy`=1. The sequence advances only on a cycle where both `memReq` and `memRdy` are 1.
- R9: A set-enable or clear-enable request causes no memory access. On the next cycle `updValid` is 1, `flgOut` is `curFlg` with bit 4 set or cleared, and `spOut` and `ipOut` equal `curSp` and `curIp`.
- R10: `updValid` is 1 for exactly one cycle per sequence. `busy` stays 1 from the cycle after acceptance through the `updValid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bndry | input | 1 | The core is at an instruction boundary |
| trapReq | input | 1 | Software interrupt or exception |
| trapVec | input | 8 | Vector of the trap |
| trapCode | input | 32 | Error code pushed by a trap |
| irqReq | input | 1 | Platform interrupt request |
| irqVec | input | 8 | Vector of the platform request |
| retReq | input | 1 | Return from handler |
| setIeReq | input | 1 | Set interrupt enable |
| clrIeReq | input | 1 | Clear interrupt enable |
| curSp | input | 32 | Current stack pointer |
| curFlg | input | 32 | Current flag word |
| curIp | input | 32 | Current instruction pointer |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memRdy |
| memRdy | input | 1 | Memory completes the access |
| busy | output | 1 | A sequence is in progress |
| updValid | output | 1 | spOut, flgOut and ipOut are to be written back |
| spOut | output | 32 | New stack pointer |
| flgOut | output | 32 | New flag word |
| ipOut | output | 32 | New instruction pointer |

## Verification
The in-line assertions check several properties on every cycle:
- a stalled access keeps its request and its address and data fields steady;
- `updValid` never lasts two cycles;
- the sequencer stays idle when no boundary is signalled;
- each push raises the stack pointer by one word;
- loading the vector leaves interrupt enable at 0.

Other behaviour can only be shown by the bench's scenarios against its behavioural model. That covers the order and addresses of the pushes and pops, the values of the error code and the table entry, precedence among requests arriving together, masking of platform requests, and the exact cycle in which the written-back values appear under random ready stalls.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PSP, S_PFLG, S_PIP, S_PCODE, S_VEC,
    S_RIP, S_RFLG, S_RSP, S_DONE
  } seqState_t;

  typedef enum logic [1:0] {A_PUSH, A_POP, A_VEC} addrSel_t;
  typedef enum logic [1:0] {W_SP, W_FLG, W_IP, W_CODE} wrSel_t;
  typedef enum logic [2:0] {C_NONE, C_TRAP, C_IRQ, C_RET, C_SIF, C_CIF} capKind_t;

  typedef struct packed {
    capKind_t cap;
    addrSel_t aSel;
    wrSel_t   wSel;
    logic     spUp;
    logic     spDown;
    logic     ldIp;
    logic     ldFlg;
    logic     ldSp;
    logic     ldVec;
  } seqCtrl_t;

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int VW      = 8,
  parameter int NMI_VEC = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bndry,
  input  logic          trapReq,
  input  logic          irqReq,
  input  logic [VW-1:0] irqVec,
  input  logic          retReq,
  input  logic          setIeReq,
  input  logic          clrIeReq,
  input  logic          ieNow,
  input  logic          memRdy,
  output seqCtrl_t      ctrl,
  output logic          memReq,
  output logic          memWe,
  output logic          busy,
  output logic          updValid
);

  seqState_t state, stateNext;
  logic      irqOk;
  logic      hs;

  assign irqOk = irqReq && (ieNow || (irqVec == VW'(NMI_VEC)));
  assign hs    = memReq && memRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctrl.cap    = C_NONE;
    ctrl.aSel   = A_PUSH;
    ctrl.wSel   = W_SP;
    ctrl.spUp   = 1'b0;
    ctrl.spDown = 1'b0;
    ctrl.ldIp   = 1'b0;
    ctrl.ldFlg  = 1'b0;
    ctrl.ldSp   = 1'b0;
    ctrl.ldVec  = 1'b0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (bndry) begin
          if (trapReq) begin
            ctrl.cap  = C_TRAP;
            stateNext = S_PSP;
          end else if (irqOk) begin
            ctrl.cap  = C_IRQ;
            stateNext = S_PSP;
          end else if (retReq) begin
            ctrl.cap  = C_RET;
            stateNext = S_RIP;
          end else if (setIeReq) begin
            ctrl.cap  = C_SIF;
            stateNext = S_DONE;
          end else if (clrIeReq) begin
            ctrl.cap  = C_CIF;
            stateNext = S_DONE;
          end
        end
      end
      S_PSP, S_PFLG, S_PIP, S_PCODE: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        ctrl.aSel = A_PUSH;
        ctrl.spUp = hs;
        unique case (state)
          S_PSP:   ctrl.wSel = W_SP;
          S_PFLG:  ctrl.wSel = W_FLG;
          S_PIP:   ctrl.wSel = W_IP;
          default: ctrl.wSel = W_CODE;
        endcase
        if (hs) begin
          unique case (state)
            S_PSP:   stateNext = S_PFLG;
            S_PFLG:  stateNext = S_PIP;
            S_PIP:   stateNext = S_PCODE;
            default: stateNext = S_VEC;
          endcase
        end
      end
      S_VEC: begin
        memReq     = 1'b1;
        ctrl.aSel  = A_VEC;
        ctrl.ldVec = hs;
        if (hs) stateNext = S_DONE;
      end
      S_RIP: begin
        memReq      = 1'b1;
        ctrl.aSel   = A_POP;
        ctrl.ldIp   = hs;
        ctrl.spDown = hs;
        if (hs) stateNext = S_RFLG;
      end
      S_RFLG: begin
        memReq      = 1'b1;
        ctrl.aSel   = A_POP;
        ctrl.ldFlg  = hs;
        ctrl.spDown = hs;
        if (hs) stateNext = S_RSP;
      end
      S_RSP: begin
        memReq    = 1'b1;
        ctrl.aSel = A_POP;
        ctrl.ldSp = hs;
        if (hs) stateNext = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign updValid = (state == S_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> !updValid); // R10
  AST_NO_BNDRY_STAY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !bndry) |=> !busy); // R2
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updValid) |-> $past(busy) || $past(setIeReq || clrIeReq)); // R9

endmodule

// File: rtl/trap_seq_dpath.sv
module trap_seq_dpath
  import trap_seq_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          VW       = 8,
  parameter int          IE_BIT   = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_F000
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtrl_t      ctrl,
  input  logic [DW-1:0] curSp,
  input  logic [DW-1:0] curFlg,
  input  logic [DW-1:0] curIp,
  input  logic [VW-1:0] trapVec,
  input  logic [DW-1:0] trapCode,
  input  logic [VW-1:0] irqVec,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] flgOut,
  output logic [DW-1:0] ipOut
);

  localparam int          STEP    = DW / 8;
  localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

  logic [DW-1:0] spR, spSave, flgR, ipR, codeR;
  logic [VW-1:0] vecR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spR    <= '0;
      spSave <= '0;
      flgR   <= '0;
      ipR    <= '0;
      codeR  <= '0;
      vecR   <= '0;
    end else begin
      unique case (ctrl.cap)
        C_TRAP, C_IRQ: begin
          spR    <= curSp;
          spSave <= curSp;
          flgR   <= curFlg;
          ipR    <= curIp;
          codeR  <= (ctrl.cap == C_TRAP) ? trapCode : DW'(irqVec);
          vecR   <= (ctrl.cap == C_TRAP) ? trapVec : irqVec;
        end
        C_RET: begin
          spR  <= curSp - DW'(STEP);
          flgR <= curFlg;
          ipR  <= curIp;
        end
        C_SIF, C_CIF: begin
          spR  <= curSp;
          ipR  <= curIp;
          flgR <= (ctrl.cap == C_SIF) ? (curFlg | IE_MASK) : (curFlg & ~IE_MASK);
        end
        default: ;
      endcase
      if (ctrl.spUp)   spR <= spR + DW'(STEP);
      if (ctrl.spDown) spR <= spR - DW'(STEP);
      if (ctrl.ldSp)   spR <= memRdata;
      if (ctrl.ldIp)   ipR <= memRdata;
      if (ctrl.ldFlg)  flgR <= memRdata;
      if (ctrl.ldVec) begin
        ipR          <= memRdata;
        flgR[IE_BIT] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (ctrl.aSel)
      A_POP:   memAddr = spR;
      A_VEC:   memAddr = VEC_BASE + DW'(vecR) * DW'(STEP);
      default: memAddr = spR + DW'(STEP);
    endcase
    unique case (ctrl.wSel)
      W_FLG:   memWdata = flgR;
      W_IP:    memWdata = ipR;
      W_CODE:  memWdata = codeR;
      default: memWdata = spSave;
    endcase
  end

  assign spOut  = spR;
  assign flgOut = flgR;
  assign ipOut  = ipR;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.spUp |=> spR == $past(spR) + DW'(STEP)); // R3
  AST_VEC_IE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.ldVec |=> !flgR[IE_BIT]); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.spDown |=> spR == $past(spR) - DW'(STEP)); // R7

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          VW       = 8,
  parameter int          IE_BIT   = 4,
  parameter int          NMI_VEC  = 1,
  parameter logic [31:0] VEC_BASE = 32'h0000_F000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bndry,
  input  logic          trapReq,
  input  logic [VW-1:0] trapVec,
  input  logic [DW-1:0] trapCode,
  input  logic          irqReq,
  input  logic [VW-1:0] irqVec,
  input  logic          retReq,
  input  logic          setIeReq,
  input  logic          clrIeReq,
  input  logic [DW-1:0] curSp,
  input  logic [DW-1:0] curFlg,
  input  logic [DW-1:0] curIp,
  output logic          memReq,
  output logic          memWe,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memRdy,
  output logic          busy,
  output logic          updValid,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] flgOut,
  output logic [DW-1:0] ipOut
);

  seqCtrl_t ctrl;

  trap_seq_ctrl #(.VW(VW), .NMI_VEC(NMI_VEC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bndry    (bndry),
    .trapReq  (trapReq),
    .irqReq   (irqReq),
    .irqVec   (irqVec),
    .retReq   (retReq),
    .setIeReq (setIeReq),
    .clrIeReq (clrIeReq),
    .ieNow    (curFlg[IE_BIT]),
    .memRdy   (memRdy),
    .ctrl     (ctrl),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .updValid (updValid)
  );

  trap_seq_dpath #(.DW(DW), .VW(VW), .IE_BIT(IE_BIT), .VEC_BASE(VEC_BASE)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .curSp    (curSp),
    .curFlg   (curFlg),
    .curIp    (curIp),
    .trapVec  (trapVec),
    .trapCode (trapCode),
    .irqVec   (irqVec),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .spOut    (spOut),
    .flgOut   (flgOut),
    .ipOut    (ipOut)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata)); // R8
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R2

endmodule

// File: tb/trap_seq_tb.sv
module trap_seq_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VBASE      = 32'h0000_F000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bndry = 1'b0, trapReq = 1'b0, irqReq = 1'b0, retReq = 1'b0;
  logic        setIeReq = 1'b0, clrIeReq = 1'b0;
  logic [7:0]  trapVec = '0, irqVec = '0;
  logic [31:0] trapCode = '0, curSp = '0, curFlg = '0, curIp = '0;
  logic        memReq, memWe, memRdy = 1'b1, busy, updValid;
  logic [31:0] memAddr, memWdata, memRdata = '0, spOut, flgOut, ipOut;

  int checks = 0;
  int fails  = 0;
  int rdyMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  trap_seq u_dut (
    .clk(clk), .rstN(rstN), .bndry(bndry), .trapReq(trapReq), .trapVec(trapVec),
    .trapCode(trapCode), .irqReq(irqReq), .irqVec(irqVec), .retReq(retReq),
    .setIeReq(setIeReq), .clrIeReq(clrIeReq), .curSp(curSp), .curFlg(curFlg),
    .curIp(curIp), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRdy(memRdy), .busy(busy),
    .updValid(updValid), .spOut(spOut), .flgOut(flgOut), .ipOut(ipOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory contents seen by the design and by the model, kept apart
  logic [31:0] dutMem [logic [31:0]];
  logic [31:0] refMem [logic [31:0]];

  function automatic logic [31:0] seedWord(logic [31:0] a);
    return a * 32'd3 + 32'h1000_0000;
  endfunction

  typedef struct packed {
    logic [31:0] a;
    logic        we;
    logic [31:0] d;
    logic [2:0]  kind;  // 0 write, 1 vector, 2 ip, 3 flg, 4 sp
    logic [3:0]  tag;
  } op_t;

  op_t mQ[$];
  logic        mDone = 1'b0;
  logic [31:0] eSp = '0, eFlg = '0, eIp = '0;
  int          seqTag = 0;

  function automatic op_t mkOp(logic [31:0] a, logic we, logic [31:0] d,
                               logic [2:0] k, logic [3:0] t);
    op_t o;
    o.a = a; o.we = we; o.d = d; o.kind = k; o.tag = t;
    return o;
  endfunction

  // reference model, advanced on every rising edge from bench-driven inputs
  always @(posedge clk) begin
    if (!rstN) begin
      mQ.delete();
      mDone = 1'b0;
    end else if (mDone) begin
      mDone = 1'b0;
    end else if (mQ.size() != 0) begin
      if (memRdy) begin
        op_t o;
        logic [31:0] rd;
        o = mQ.pop_front();
        if (o.we) refMem[o.a] = o.d;
        else begin
          rd = refMem.exists(o.a) ? refMem[o.a] : seedWord(o.a);
          case (o.kind)
            3'd1: begin eIp = rd; eFlg[4] = 1'b0; end
            3'd2: eIp = rd;
            3'd3: eFlg = rd;
            default: eSp = rd;
          endcase
        end
        if (mQ.size() == 0) mDone = 1'b1;
      end
    end else if (bndry) begin
      logic irqTaken;
      irqTaken = irqReq && (curFlg[4] || irqVec == 8'd1);
      if (trapReq || irqTaken) begin
        logic [31:0] code;
        logic [7:0]  v;
        v    = trapReq ? trapVec : irqVec;
        code = trapReq ? trapCode : {24'd0, irqVec};
        mQ.push_back(mkOp(curSp + 4,  1'b1, curSp,  3'd0, 4'd3));
        mQ.push_back(mkOp(curSp + 8,  1'b1, curFlg, 3'd0, 4'd3));
        mQ.push_back(mkOp(curSp + 12, 1'b1, curIp,  3'd0, 4'd3));
        mQ.push_back(mkOp(curSp + 16, 1'b1, code,   3'd0, 4'd3));
        mQ.push_back(mkOp(VBASE + {22'd0, v, 2'b00}, 1'b0, '0, 3'd1, 4'd4));
        eSp = curSp + 16; eFlg = curFlg; eIp = curIp; seqTag = 5;
      end else if (retReq) begin
        mQ.push_back(mkOp(curSp - 4,  1'b0, '0, 3'd2, 4'd7));
        mQ.push_back(mkOp(curSp - 8,  1'b0, '0, 3'd3, 4'd7));
        mQ.push_back(mkOp(curSp - 12, 1'b0, '0, 3'd4, 4'd7));
        eSp = curSp; eFlg = curFlg; eIp = curIp; seqTag = 7;
      end else if (setIeReq || clrIeReq) begin
        eSp = curSp; eIp = curIp; seqTag = 9;
        eFlg = setIeReq ? (curFlg | 32'h10) : (curFlg & ~32'h10);
        mDone = 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  // per-cycle comparison, then ready, read data and memory writes
  always @(negedge clk) begin
    if (rstN) begin
      chk("R10 busy", {31'd0, busy}, {31'd0, (mQ.size() != 0) || mDone});
      chk("R2 R6 memReq", {31'd0, memReq}, {31'd0, mQ.size() != 0});
      chk("R10 updValid", {31'd0, updValid}, {31'd0, mDone});
      if (mQ.size() != 0) begin
        chk($sformatf("R%0d R8 memAddr", mQ[0].tag), memAddr, mQ[0].a);
        chk($sformatf("R%0d R8 memWe", mQ[0].tag), {31'd0, memWe}, {31'd0, mQ[0].we});
        if (mQ[0].we) chk("R3 R8 memWdata", memWdata, mQ[0].d);
      end
      if (mDone) begin
        chk($sformatf("R%0d spOut", seqTag), spOut, eSp);
        chk($sformatf("R%0d flgOut", seqTag), flgOut, eFlg);
        chk($sformatf("R%0d ipOut", seqTag), ipOut, eIp);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memRdy = (rdyMode == 0) ? 1'b1 : lfsr[0];
    memRdata = dutMem.exists(memAddr) ? dutMem[memAddr] : seedWord(memAddr);
    if (memReq && memRdy && memWe) dutMem[memAddr] = memWdata;
  end

  task automatic clearReqs();
    bndry = 0; trapReq = 0; irqReq = 0; retReq = 0; setIeReq = 0; clrIeReq = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (mQ.size() != 0 || mDone);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    clearReqs();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 memReq", {31'd0, memReq}, 32'd0);
    chk("R1 updValid", {31'd0, updValid}, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R3 R4 R5: trap entry, vector 0
    curSp = 32'h0000_2000; curFlg = 32'h0000_0015; curIp = 32'h0000_0400;
    bndry = 1; trapReq = 1; trapVec = 8'd0; trapCode = 32'hDEAD_0001;
    pulse(); waitIdle();

    // R2: requests off an instruction boundary are ignored
    trapReq = 1; irqReq = 1; irqVec = 8'd1; retReq = 1; setIeReq = 1;
    repeat (4) @(negedge clk);
    clearReqs(); @(negedge clk);

    // R6: masked platform request ignored, then taken once enabled
    curFlg = 32'h0000_0003; bndry = 1; irqReq = 1; irqVec = 8'd20;
    repeat (3) @(negedge clk);
    clearReqs(); @(negedge clk);
    curFlg = 32'h0000_0013; bndry = 1; irqReq = 1; irqVec = 8'd20;
    pulse(); waitIdle();

    // R6: vector 1 taken with enable clear, random stalls (R8)
    rdyMode = 1;
    curSp = 32'h0000_3000; curFlg = 32'h0000_0001;
    bndry = 1; irqReq = 1; irqVec = 8'd1;
    pulse(); waitIdle();

    // R2: precedence, trap wins over platform and return; requests held while busy
    curSp = 32'h0000_4000; curFlg = 32'h0000_001C; curIp = 32'h0000_0888;
    bndry = 1; trapReq = 1; trapVec = 8'd255; trapCode = 32'h0000_00AA;
    irqReq = 1; irqVec = 8'd40; retReq = 1;
    @(negedge clk);
    trapReq = 0;
    repeat (6) @(negedge clk);
    clearReqs(); waitIdle();

    // R7: return from the frame just pushed
    curSp = 32'h0000_4010; curFlg = 32'h0; curIp = 32'h0000_9999;
    bndry = 1; retReq = 1;
    pulse(); waitIdle();

    // R2: platform beats return when enabled
    rdyMode = 0;
    curSp = 32'h0000_5000; curFlg = 32'h0000_0010;
    bndry = 1; irqReq = 1; irqVec = 8'd16; retReq = 1;
    pulse(); waitIdle();

    // R9: set-enable wins over clear-enable, then clear alone
    curSp = 32'h0000_6000; curFlg = 32'h0000_0002; curIp = 32'h0000_0123;
    bndry = 1; setIeReq = 1; clrIeReq = 1;
    pulse(); waitIdle();
    curFlg = 32'hFFFF_FFFF;
    bndry = 1; clrIeReq = 1;
    pulse(); waitIdle();

    // R4 R7: trap on vector 128 under stalls, then its return
    rdyMode = 1;
    curSp = 32'h0001_0000; curFlg = 32'h0000_0019; curIp = 32'h0000_7770;
    bndry = 1; trapReq = 1; trapVec = 8'd128; trapCode = 32'h1234_5678;
    pulse(); waitIdle();
    curSp = 32'h0001_0010;
    bndry = 1; retReq = 1;
    pulse(); waitIdle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule